// File: doc/BRIEF.md
# Reorder Buffer With Exception Flush

This block keeps instructions of an out-of-order core in program order between dispatch and retirement. Dispatch allocates one entry per cycle at the tail and receives a tag that downstream reservation stations carry. Execution units report results out of order on a completion bus, keyed by that tag. The head entry retires in order, one per cycle, through a register-file write port once its result is present.

Tags run from 1 to `DEPTH`, so a tag of zero can mean "value lives in the register file" elsewhere in the core. When the head entry reports an exception, the block writes nothing. It raises a one-cycle flush pulse naming the faulting tag, and then restarts with an empty buffer at tag 1.

A two-state controller sequences the block. The states are `ROB_RUN` for normal operation and `ROB_FLUSH` for the clearing cycle. There are two transitions:
- **RUN to FLUSH**: taken when the head entry is valid, complete and flagged with an exception.
- **FLUSH to RUN**: always taken after one cycle.

Top module: `reorder_buffer`

## Requirements
- R1: After reset the buffer is empty: `disp_ready_o`=1, `disp_tag_o`=1, `rf_we_o`=0, `flush_o`=0.
- R2: Successive dispatches receive tags 1, 2, ..., DEPTH and then wrap back to 1. A tag offered with `disp_ready_o` high is never 0.
- R3: Once DEPTH entries are occupied, `disp_ready_o` is 0 and a dispatch request has no effect.
- R4: A completion stores its value and exception flag in the entry named by `cmpl_tag_i` and marks that entry complete. A completion naming an entry that is not allocated is ignored.
- R5: Only the head entry retires. While it is incomplete, `rf_we_o` stays 0 even when younger entries have completed. A retiring entry drives `rf_we_o`=1, its destination on `rf_addr_o`, its value on `rf_data_o` and its tag on `retire_tag_o`, in the same cycle its completion is visible.
- R6: At most one entry retires per cycle. A dispatch and a retirement in the same cycle leave the occupancy unchanged.
- R7: A complete head entry that carries an exception produces no register write. In the next cycle `flush_o` is 1 for exactly one cycle, with `flush_tag_o` equal to the faulting tag and `disp_ready_o`=0.
- R8: After the flush cycle the buffer is empty and the next dispatch receives tag 1. Results completed before the flush never retire from reallocated entries.
- R9: An exception in an entry other than the head causes no flush. Older entries retire normally first, and the flush starts only after the faulting entry becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid_i | input | 1 | Dispatch request |
| disp_areg_i | input | AREG_W | Destination architectural register of the dispatched instruction |
| disp_ready_o | output | 1 | An entry can be allocated this cycle |
| disp_tag_o | output | TAG_W | Tag assigned to a dispatch accepted this cycle |
| cmpl_valid_i | input | 1 | Completion broadcast valid |
| cmpl_tag_i | input | TAG_W | Tag of the completing entry |
| cmpl_value_i | input | DATA_W | Result value |
| cmpl_exc_i | input | 1 | Completing instruction raised an exception |
| rf_we_o | output | 1 | Register-file write enable (head retires) |
| rf_addr_o | output | AREG_W | Register-file write address |
| rf_data_o | output | DATA_W | Register-file write data |
| retire_tag_o | output | TAG_W | Tag of the head entry |
| flush_o | output | 1 | Clear all speculative state this cycle |
| flush_tag_o | output | TAG_W | Tag of the faulting instruction during a flush |

## Verification
On every cycle, the assertions check the following:
- the range of offered tags;
- the stall when the buffer is full;
- consecutive retirements following tag order with wrap;
- occupancy holding when allocation and retirement coincide;
- the flush being a single silent pulse followed by an empty buffer at tag 1.

Only the bench scenarios can show the rest:
- that out-of-order completions wait behind an incomplete head;
- that a stray completion to a free entry leaves no trace;
- that stale results do not survive a flush;
- that an exception deep in the buffer waits until it reaches the head.

// File: rtl/rob_pkg.sv
package rob_pkg;
    typedef enum logic [0:0] {
        ROB_RUN   = 1'b0,
        ROB_FLUSH = 1'b1
    } rob_state_e;
endpackage

// File: rtl/rob_ptr.sv
module rob_ptr #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    input  logic             clr,
    output logic [TAG_W-1:0] tag_o
);
    localparam logic [TAG_W-1:0] FIRST = TAG_W'(1);
    localparam logic [TAG_W-1:0] LAST  = TAG_W'(DEPTH);

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            tag_o <= FIRST;
        end else if (adv) begin
            tag_o <= (tag_o == LAST) ? FIRST : tag_o + FIRST;
        end
    end
endmodule

// File: rtl/rob_store.sv
module rob_store #(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              alloc_en,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic [AREG_W-1:0] alloc_areg,
    input  logic              cmpl_en,
    input  logic [TAG_W-1:0]  cmpl_tag,
    input  logic [DATA_W-1:0] cmpl_value,
    input  logic              cmpl_exc,
    input  logic              free_en,
    input  logic [TAG_W-1:0]  rd_tag,
    output logic              rd_valid,
    output logic              rd_done,
    output logic              rd_exc,
    output logic [AREG_W-1:0] rd_areg,
    output logic [DATA_W-1:0] rd_value
);
    logic              valid_q [1:DEPTH];
    logic              done_q  [1:DEPTH];
    logic              exc_q   [1:DEPTH];
    logic [AREG_W-1:0] areg_q  [1:DEPTH];
    logic [DATA_W-1:0] value_q [1:DEPTH];

    for (genvar i = 1; i <= DEPTH; i++) begin : g_entry
        localparam logic [TAG_W-1:0] MY_TAG = TAG_W'(i);
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                valid_q[i] <= 1'b0;
                done_q[i]  <= 1'b0;
                exc_q[i]   <= 1'b0;
                areg_q[i]  <= '0;
                value_q[i] <= '0;
            end else begin
                if (free_en && rd_tag == MY_TAG) begin
                    valid_q[i] <= 1'b0;
                    done_q[i]  <= 1'b0;
                    exc_q[i]   <= 1'b0;
                end
                if (alloc_en && alloc_tag == MY_TAG) begin
                    valid_q[i] <= 1'b1;
                    done_q[i]  <= 1'b0;
                    exc_q[i]   <= 1'b0;
                    areg_q[i]  <= alloc_areg;
                end else if (cmpl_en && cmpl_tag == MY_TAG && valid_q[i]) begin
                    done_q[i]  <= 1'b1;
                    exc_q[i]   <= cmpl_exc;
                    value_q[i] <= cmpl_value;
                end
            end
        end
    end

    always_comb begin
        rd_valid = 1'b0;
        rd_done  = 1'b0;
        rd_exc   = 1'b0;
        rd_areg  = '0;
        rd_value = '0;
        for (int k = 1; k <= DEPTH; k++) begin
            if (rd_tag == TAG_W'(k)) begin
                rd_valid = valid_q[k];
                rd_done  = done_q[k];
                rd_exc   = exc_q[k];
                rd_areg  = areg_q[k];
                rd_value = value_q[k];
            end
        end
    end
endmodule

// File: rtl/reorder_buffer.sv
module reorder_buffer
    import rob_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int AREG_W = 5,
    parameter int DATA_W = 32,
    parameter int TAG_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              disp_valid_i,
    input  logic [AREG_W-1:0] disp_areg_i,
    output logic              disp_ready_o,
    output logic [TAG_W-1:0]  disp_tag_o,
    input  logic              cmpl_valid_i,
    input  logic [TAG_W-1:0]  cmpl_tag_i,
    input  logic [DATA_W-1:0] cmpl_value_i,
    input  logic              cmpl_exc_i,
    output logic              rf_we_o,
    output logic [AREG_W-1:0] rf_addr_o,
    output logic [DATA_W-1:0] rf_data_o,
    output logic [TAG_W-1:0]  retire_tag_o,
    output logic              flush_o,
    output logic [TAG_W-1:0]  flush_tag_o
);
    localparam int                CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0]  FULL  = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0]  ONE   = CNT_W'(1);

    rob_state_e        state_q, state_d;
    logic [CNT_W-1:0]  count_q;
    logic [TAG_W-1:0]  head_tag, tail_tag;
    logic              head_valid, head_done, head_exc;
    logic [AREG_W-1:0] head_areg;
    logic [DATA_W-1:0] head_value;
    logic              alloc, retire, clearing, exc_at_head;

    rob_ptr #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_head (
        .clk(clk), .rst_n(rst_n), .adv(retire), .clr(clearing), .tag_o(head_tag)
    );

    rob_ptr #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_tail (
        .clk(clk), .rst_n(rst_n), .adv(alloc), .clr(clearing), .tag_o(tail_tag)
    );

    rob_store #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_store (
        .clk(clk), .rst_n(rst_n), .clr(clearing),
        .alloc_en(alloc), .alloc_tag(tail_tag), .alloc_areg(disp_areg_i),
        .cmpl_en(cmpl_valid_i && !clearing), .cmpl_tag(cmpl_tag_i),
        .cmpl_value(cmpl_value_i), .cmpl_exc(cmpl_exc_i),
        .free_en(retire), .rd_tag(head_tag),
        .rd_valid(head_valid), .rd_done(head_done), .rd_exc(head_exc),
        .rd_areg(head_areg), .rd_value(head_value)
    );

    assign exc_at_head = head_valid && head_done && head_exc;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ROB_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ROB_RUN:   if (exc_at_head) state_d = ROB_FLUSH;
            ROB_FLUSH: state_d = ROB_RUN;
            default:   state_d = ROB_RUN;
        endcase
    end

    // outputs
    always_comb begin
        clearing     = 1'b0;
        disp_ready_o = 1'b0;
        retire       = 1'b0;
        unique case (state_q)
            ROB_RUN: begin
                disp_ready_o = (count_q != FULL);
                retire       = head_valid && head_done && !head_exc;
            end
            ROB_FLUSH: clearing = 1'b1;
            default:   clearing = 1'b1;
        endcase
    end

    assign alloc        = disp_valid_i && disp_ready_o;
    assign disp_tag_o   = tail_tag;
    assign rf_we_o      = retire;
    assign rf_addr_o    = head_areg;
    assign rf_data_o    = head_value;
    assign retire_tag_o = head_tag;
    assign flush_o      = clearing;
    assign flush_tag_o  = head_tag;

    always_ff @(posedge clk) begin
        if (!rst_n || clearing) begin
            count_q <= '0;
        end else if (alloc && !retire) begin
            count_q <= count_q + ONE;
        end else if (retire && !alloc) begin
            count_q <= count_q - ONE;
        end
    end
endmodule

// File: rtl/rob_checker.sv
module rob_checker #(
    parameter int DEPTH = 8,
    parameter int TAG_W = $clog2(DEPTH + 1),
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             disp_valid_i,
    input logic             disp_ready_o,
    input logic [TAG_W-1:0] disp_tag_o,
    input logic             rf_we_o,
    input logic [TAG_W-1:0] retire_tag_o,
    input logic             flush_o,
    input logic [CNT_W-1:0] occ
);
    localparam logic [TAG_W-1:0] LAST  = TAG_W'(DEPTH);
    localparam logic [TAG_W-1:0] FIRST = TAG_W'(1);
    localparam logic [CNT_W-1:0] FULL  = CNT_W'(DEPTH);

    logic [TAG_W-1:0] nxt_q;
    always_ff @(posedge clk) begin
        nxt_q <= (retire_tag_o == LAST) ? FIRST : retire_tag_o + FIRST;
    end

    AST_TAG_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        disp_ready_o |-> (disp_tag_o != '0 && disp_tag_o <= LAST)); // R2
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == FULL) |-> !disp_ready_o); // R3
    AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we_o |=> (!rf_we_o || retire_tag_o == nxt_q)); // R5
    AST_OCC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (disp_valid_i && disp_ready_o && rf_we_o) |=> (occ == $past(occ))); // R6
    AST_FLUSH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> (!rf_we_o && !disp_ready_o)); // R7
    AST_FLUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> (!flush_o && occ == '0 && disp_tag_o == FIRST)); // R8
endmodule

bind reorder_buffer rob_checker #(.DEPTH(DEPTH), .TAG_W(TAG_W), .CNT_W(CNT_W)) u_rob_checker (
    .clk(clk), .rst_n(rst_n), .disp_valid_i(disp_valid_i), .disp_ready_o(disp_ready_o),
    .disp_tag_o(disp_tag_o), .rf_we_o(rf_we_o), .retire_tag_o(retire_tag_o),
    .flush_o(flush_o), .occ(count_q)
);

// File: tb/reorder_buffer_bench.sv
module reorder_buffer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int AREG_W = 5;
    localparam int DATA_W = 32;
    localparam int TAG_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n;
    logic              disp_valid_i;
    logic [AREG_W-1:0] disp_areg_i;
    logic              disp_ready_o;
    logic [TAG_W-1:0]  disp_tag_o;
    logic              cmpl_valid_i;
    logic [TAG_W-1:0]  cmpl_tag_i;
    logic [DATA_W-1:0] cmpl_value_i;
    logic              cmpl_exc_i;
    logic              rf_we_o;
    logic [AREG_W-1:0] rf_addr_o;
    logic [DATA_W-1:0] rf_data_o;
    logic [TAG_W-1:0]  retire_tag_o;
    logic              flush_o;
    logic [TAG_W-1:0]  flush_tag_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    reorder_buffer #(.DEPTH(DEPTH), .AREG_W(AREG_W), .DATA_W(DATA_W)) u_reorder_buffer (
        .clk(clk), .rst_n(rst_n),
        .disp_valid_i(disp_valid_i), .disp_areg_i(disp_areg_i),
        .disp_ready_o(disp_ready_o), .disp_tag_o(disp_tag_o),
        .cmpl_valid_i(cmpl_valid_i), .cmpl_tag_i(cmpl_tag_i),
        .cmpl_value_i(cmpl_value_i), .cmpl_exc_i(cmpl_exc_i),
        .rf_we_o(rf_we_o), .rf_addr_o(rf_addr_o), .rf_data_o(rf_data_o),
        .retire_tag_o(retire_tag_o), .flush_o(flush_o), .flush_tag_o(flush_tag_o)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input longint act, input longint exp);
        chk(act == exp, req, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        disp_valid_i = 1'b0;
        cmpl_valid_i = 1'b0;
        cmpl_exc_i   = 1'b0;
    endtask

    task automatic set_disp(input int areg);
        disp_valid_i = 1'b1;
        disp_areg_i  = AREG_W'(areg);
    endtask

    task automatic set_cmpl(input int tag, input int value, input bit exc);
        cmpl_valid_i = 1'b1;
        cmpl_tag_i   = TAG_W'(tag);
        cmpl_value_i = DATA_W'(value);
        cmpl_exc_i   = exc;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        disp_valid_i = 1'b0; disp_areg_i = '0;
        cmpl_valid_i = 1'b0; cmpl_tag_i = '0; cmpl_value_i = '0; cmpl_exc_i = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        chk_eq("R1 ready", disp_ready_o, 1);
        chk_eq("R1 tag", disp_tag_o, 1);
        chk_eq("R1 rf_we", rf_we_o, 0);
        chk_eq("R1 flush", flush_o, 0);
    endtask

    task automatic t_fill_and_retire();
        for (int i = 1; i <= DEPTH; i++) begin
            chk_eq("R2 sequential tag", disp_tag_o, i);
            set_disp(i);
            tick();
        end
        chk_eq("R3 full stall", disp_ready_o, 0);
        set_disp(20);
        tick();
        chk_eq("R3 request while full ignored", disp_ready_o, 0);
        set_cmpl(3, 'h103, 1'b0);
        tick();
        chk_eq("R5 younger waits for head", rf_we_o, 0);
        set_cmpl(1, 'h101, 1'b0);
        tick();
        chk_eq("R5 head retires", rf_we_o, 1);
        chk_eq("R5 retire addr", rf_addr_o, 1);
        chk_eq("R5 retire data", rf_data_o, 'h101);
        chk_eq("R5 retire tag", retire_tag_o, 1);
        tick();
        chk_eq("R5 incomplete head stalls", rf_we_o, 0);
        chk_eq("R2 ready after retire", disp_ready_o, 1);
        chk_eq("R2 tag wraps to 1", disp_tag_o, 1);
        set_disp(9);
        set_cmpl(2, 'h102, 1'b0);
        tick();
        chk_eq("R4 completion stored", rf_data_o, 'h102);
        chk_eq("R5 retire tag 2", retire_tag_o, 2);
        chk_eq("R3 full again", disp_ready_o, 0);
        tick();
        chk_eq("R5 next head retires", rf_we_o, 1);
        chk_eq("R5 retire tag 3", retire_tag_o, 3);
        chk_eq("R5 retire data 3", rf_data_o, 'h103);
        chk_eq("R6 ready with one slot", disp_ready_o, 1);
        set_disp(10);
        tick();
        chk_eq("R6 occupancy held", disp_ready_o, 1);
        chk_eq("R6 tail advanced", disp_tag_o, 3);
        chk_eq("R6 single retire", rf_we_o, 0);
    endtask

    task automatic t_head_exception();
        set_cmpl(1, 'h999, 1'b0);
        tick();
        chk_eq("R5 young completion waits", rf_we_o, 0);
        set_cmpl(4, 'h444, 1'b1);
        tick();
        chk_eq("R7 no write on exception", rf_we_o, 0);
        chk_eq("R7 flush not yet", flush_o, 0);
        tick();
        chk_eq("R7 flush pulse", flush_o, 1);
        chk_eq("R7 flush tag", flush_tag_o, 4);
        chk_eq("R7 dispatch blocked", disp_ready_o, 0);
        chk_eq("R7 no write in flush", rf_we_o, 0);
        tick();
        chk_eq("R7 flush one cycle", flush_o, 0);
        chk_eq("R8 ready after flush", disp_ready_o, 1);
        chk_eq("R8 tag restarts", disp_tag_o, 1);
    endtask

    task automatic t_after_flush();
        set_cmpl(2, 'h777, 1'b0);
        tick();
        set_disp(11);
        tick();
        chk_eq("R8 stale result not retired", rf_we_o, 0);
        set_disp(12);
        tick();
        set_cmpl(1, 'h201, 1'b0);
        tick();
        chk_eq("R8 fresh retire", rf_we_o, 1);
        chk_eq("R8 fresh addr", rf_addr_o, 11);
        chk_eq("R8 fresh data", rf_data_o, 'h201);
        tick();
        chk_eq("R4 completion to free entry ignored", rf_we_o, 0);
    endtask

    task automatic t_deep_exception();
        set_disp(13);
        tick();
        set_cmpl(3, 'h333, 1'b1);
        tick();
        chk_eq("R9 no flush while not head", flush_o, 0);
        chk_eq("R9 no write", rf_we_o, 0);
        tick();
        chk_eq("R9 still no flush", flush_o, 0);
        set_cmpl(2, 'h202, 1'b0);
        tick();
        chk_eq("R9 older retires first", rf_we_o, 1);
        chk_eq("R9 older addr", rf_addr_o, 12);
        chk_eq("R9 older tag", retire_tag_o, 2);
        tick();
        chk_eq("R9 faulting head no write", rf_we_o, 0);
        chk_eq("R9 detect cycle no flush", flush_o, 0);
        tick();
        chk_eq("R9 flush at head", flush_o, 1);
        chk_eq("R9 flush tag", flush_tag_o, 3);
        tick();
        chk_eq("R8 restart tag", disp_tag_o, 1);
        chk_eq("R8 flush ended", flush_o, 0);
    endtask

    initial begin
        t_reset();
        t_fill_and_retire();
        t_head_exception();
        t_after_flush();
        t_deep_exception();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule